// File: doc/BRIEF.md
# SMBus Register Target with CRC-8 Packet Checking

This block is a serial-bus target that runs entirely in the system clock domain. It samples the bus clock and data lines through synchronizers and detects start and stop conditions from the sampled levels. It answers only to its fixed 7-bit address, and it pulls the data line low through an open-drain enable output. A write transaction carries a pointer byte and then one data byte. A read transaction returns the byte at the current pointer. The pointer is normally set by a short write followed by a repeated start.

Pointers below `RW_REGS` select storage cells inside the block. Every other pointer is read-only. Data for a read-only pointer comes from the surrounding core through a read request port. One pointer, `STROBE_PTR`, is a command and not a storage location: a write to it raises a single-cycle strobe. Packet error checking is optional and is decided by the master. If the master clocks one more byte after the data, that byte is compared against a CRC-8 of the transaction. On a read, the target offers the CRC byte if the master acknowledges the data byte.

A write takes effect only at the stop condition. This lets the packet check veto the write before anything reaches the register cells or the core.

Top module: `smb_target`

## Requirements
- R1: A falling data line while the clock is high is a start; a rising data line while the clock is high is a stop. A start, including a repeated start, discards any write still waiting for a stop.
- R2: The first byte after a start is a 7-bit address followed by a direction bit (0 = write, 1 = read), MSB first. Only address 0x4C (byte 0x98 or 0x99) is acknowledged, by pulling data low for the ninth clock. For any other address the data line stays released until the next start.
- R3: The target changes its data-line drive only while the bus clock is low; `sda_oe_o` = 1 pulls the line low.
- R4: A write of pointer P < 8 followed by a data byte D and a stop stores D in cell P and pulses `wr_valid_o` for one cycle with `wr_addr_o` = P and `wr_data_o` = D.
- R5: A write of pointer P, then a repeated start and address 0x99, returns the byte at P MSB first.
- R6: Pointers 8 and above are read-only. A write to one is acknowledged but produces no write strobe. A read of one pulses `rd_req_o` for one cycle with `rd_addr_o` = P and returns `rd_data_i` as sampled in that cycle.
- R7: A write to pointer 0x0F stores nothing and gives no write strobe. At the stop it gives exactly one single-cycle `meas_strobe_o` pulse, whatever the data byte.
- R8: A byte after the data byte of a write is a packet check byte. The CRC-8 uses polynomial 0x07, starts at 0x00 at each start and is applied MSB first over every byte since that start. A matching check byte is acknowledged. A mismatching one is not acknowledged, and the pending write is dropped.
- R9: On a read, if the master acknowledges the data byte, the target next sends the CRC-8 of the address byte and the data byte.
- R10: If the master does not acknowledge a byte it read, the target sends nothing more and keeps the data line released until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| wr_valid_o | output | 1 | One-cycle pulse: a storage cell was written |
| wr_addr_o | output | 8 | Pointer of the written cell |
| wr_data_o | output | 8 | Value written |
| meas_strobe_o | output | 1 | One-cycle command strobe |
| rd_req_o | output | 1 | One-cycle request for a read-only byte |
| rd_addr_o | output | 8 | Pointer of the requested byte |
| rd_data_i | input | 8 | Byte returned by the core, same cycle as the request |

## Verification
Two events can meet on one stop condition. The verdict on the packet check byte is made at the ninth clock. The commit of the pending write follows a few clocks later, at the stop. The bench provokes this by sending a corrupted check byte with a stop immediately behind it, both for a storage pointer and for the command pointer. It judges the result by an unacknowledged check byte, no `wr_valid_o` or `meas_strobe_o` pulse, and a later read that still returns the older value. Random transactions mix correct, corrupted and absent check bytes over storage, read-only and command pointers against a model of the cells.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [7:0] CRC_POLY = 8'h07;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_TX_LOAD
  } link_state_e;

  typedef enum logic [2:0] {
    BY_ADDR, BY_PTR, BY_DATA, BY_PEC, BY_EXTRA
  } byte_slot_e;

  // bit-serial CRC step, MSB of data first
  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
    logic [7:0] r;
    r = crc;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ din[i]) r = {r[6:0], 1'b0} ^ CRC_POLY;
      else               r = {r[6:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/smb_bus_sense.sv
module smb_bus_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        scl_pipe[s] <= scl_pipe[s-1];
        sda_pipe[s] <= sda_pipe[s-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[LAST];
  assign sda_s      = sda_pipe[LAST];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges count as conditions only with the clock high on both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [7:0] fetch_data_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic [7:0] wdata_o,
  output logic       commit_o,
  output logic       fetch_o
);
  localparam logic [3:0] BITS = 4'd8;

  link_state_e state_q;
  byte_slot_e  slot_q, slot_nx;
  logic [3:0]  cnt_q;
  logic [7:0]  rx_q, tx_q, crc_q, ptr_q, pend_q;
  logic        pend_vld_q, rw_q, oe_q, tx_pec_q, commit_q;

  always_comb begin
    case (slot_q)
      BY_ADDR: slot_nx = BY_PTR;
      BY_PTR:  slot_nx = BY_DATA;
      BY_DATA: slot_nx = BY_PEC;
      default: slot_nx = BY_EXTRA;
    endcase
  end

  // read data is fetched at the fall that ends the address acknowledge
  assign fetch_o = (state_q == ST_RX_ACK) && scl_fall_i && (slot_q == BY_ADDR) && rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      slot_q     <= BY_ADDR;
      cnt_q      <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      crc_q      <= '0;
      ptr_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      tx_pec_q   <= 1'b0;
      commit_q   <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (start_i) begin
        state_q    <= ST_RX;
        slot_q     <= BY_ADDR;
        cnt_q      <= '0;
        crc_q      <= '0;
        oe_q       <= 1'b0;
        pend_vld_q <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        oe_q       <= 1'b0;
        commit_q   <= pend_vld_q;
        pend_vld_q <= 1'b0;
      end else begin
        case (state_q)
          ST_RX: begin
            if (scl_rise_i && cnt_q != BITS) begin
              rx_q  <= {rx_q[6:0], sda_s_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == BITS) begin
              cnt_q   <= '0;
              oe_q    <= 1'b1;
              state_q <= ST_RX_ACK;
              case (slot_q)
                BY_ADDR: begin
                  crc_q <= crc8_step(crc_q, rx_q);
                  rw_q  <= rx_q[0];
                  if (rx_q[7:1] != DEV_ADDR) begin
                    oe_q    <= 1'b0;
                    state_q <= ST_IDLE;
                  end
                end
                BY_PTR: begin
                  crc_q <= crc8_step(crc_q, rx_q);
                  ptr_q <= rx_q;
                end
                BY_DATA: begin
                  crc_q      <= crc8_step(crc_q, rx_q);
                  pend_q     <= rx_q;
                  pend_vld_q <= 1'b1;
                end
                BY_PEC: begin
                  if (rx_q != crc_q) begin
                    oe_q       <= 1'b0;
                    pend_vld_q <= 1'b0;
                    state_q    <= ST_IDLE;
                  end
                end
                default: begin
                  oe_q       <= 1'b0;
                  pend_vld_q <= 1'b0;
                  state_q    <= ST_IDLE;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              oe_q <= 1'b0;
              if (slot_q == BY_ADDR && rw_q) begin
                tx_q     <= fetch_data_i;
                crc_q    <= crc8_step(crc_q, fetch_data_i);
                oe_q     <= ~fetch_data_i[7];
                tx_pec_q <= 1'b0;
                cnt_q    <= '0;
                state_q  <= ST_TX;
              end else begin
                slot_q  <= slot_nx;
                state_q <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd7) begin
                oe_q    <= 1'b0;
                state_q <= ST_TX_ACK;
              end else begin
                tx_q  <= {tx_q[6:0], 1'b0};
                oe_q  <= ~tx_q[6];
                cnt_q <= cnt_q + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) state_q <= sda_s_i ? ST_IDLE : ST_TX_LOAD;
          end
          ST_TX_LOAD: begin
            if (scl_fall_i) begin
              if (!tx_pec_q) begin
                tx_q     <= crc_q;
                oe_q     <= ~crc_q[7];
                tx_pec_q <= 1'b1;
                cnt_q    <= '0;
                state_q  <= ST_TX;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_o    = ptr_q;
  assign wdata_o  = pend_q;
  assign commit_o = commit_q;

  assert_sda_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> $past(scl_fall_i || start_i || stop_i));

  assert_idle_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);

  assert_tx_ack_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_ACK) |-> !oe_q);
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int         RW_REGS    = 8,
  parameter logic [7:0] STROBE_PTR = 8'h0F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic [7:0] ptr_i,
  input  logic [7:0] wdata_i,
  input  logic       fetch_i,
  output logic [7:0] fetch_data_o,
  input  logic [7:0] rd_data_i,
  output logic       rd_req_o,
  output logic [7:0] rd_addr_o,
  output logic       wr_valid_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       meas_o
);
  localparam int         IDXW   = (RW_REGS > 1) ? $clog2(RW_REGS) : 1;
  localparam logic [7:0] RW_LIM = 8'(RW_REGS);

  logic [7:0]      cells [RW_REGS];
  logic            in_rw;
  logic [IDXW-1:0] idx;

  assign in_rw = ptr_i < RW_LIM;
  assign idx   = ptr_i[IDXW-1:0];

  for (genvar g = 0; g < RW_REGS; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       cells[g] <= '0;
      else if (commit_i && in_rw && idx == IDXW'(g))    cells[g] <= wdata_i;
    end
  end

  assign fetch_data_o = in_rw ? cells[idx] : rd_data_i;
  assign rd_req_o     = fetch_i && !in_rw;
  assign rd_addr_o    = ptr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      meas_o     <= 1'b0;
    end else begin
      wr_valid_o <= commit_i && in_rw;
      meas_o     <= commit_i && (ptr_i == STROBE_PTR);
      if (commit_i && in_rw) begin
        wr_addr_o <= ptr_i;
        wr_data_o <= wdata_i;
      end
    end
  end

  assert_meas_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_o |=> !meas_o);

  assert_meas_no_store_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(meas_o && wr_valid_o));

  assert_rd_req_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
endmodule

// File: rtl/smb_target.sv
module smb_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         RW_REGS     = 8,
  parameter logic [7:0] STROBE_PTR  = 8'h0F,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_valid_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic       meas_strobe_o,
  output logic       rd_req_o,
  output logic [7:0] rd_addr_o,
  input  logic [7:0] rd_data_i
);
  logic       sda_s, scl_rise, scl_fall, start, stop;
  logic       commit, fetch;
  logic [7:0] ptr, wdata, fetch_data;

  smb_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  smb_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sda_s_i      (sda_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start),
    .stop_i       (stop),
    .fetch_data_i (fetch_data),
    .sda_oe_o     (sda_oe_o),
    .ptr_o        (ptr),
    .wdata_o      (wdata),
    .commit_o     (commit),
    .fetch_o      (fetch)
  );

  smb_regbank #(.RW_REGS(RW_REGS), .STROBE_PTR(STROBE_PTR)) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .ptr_i        (ptr),
    .wdata_i      (wdata),
    .fetch_i      (fetch),
    .fetch_data_o (fetch_data),
    .rd_data_i    (rd_data_i),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .wr_valid_o   (wr_valid_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .meas_o       (meas_strobe_o)
  );
endmodule

// File: tb/smb_target_bench.sv
module smb_target_bench;
  localparam int H = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe_o, wr_valid_o, meas_strobe_o, rd_req_o;
  logic [7:0] wr_addr_o, wr_data_o, rd_addr_o, rd_data_i;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int wr_cnt = 0, meas_cnt = 0, rd_cnt = 0, oe_viol = 0;
  logic [7:0] last_wa = '0, last_wd = '0;
  logic       oe_prev = 1'b0;
  logic [7:0] model [8];

  always #2 clk_i = ~clk_i;

  assign sda_line  = sda_m & ~sda_oe_o;
  assign rd_data_i = rd_addr_o ^ 8'h5A;

  smb_target u_smb_target (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .meas_strobe_o(meas_strobe_o), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i)
  );

  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (wr_valid_o) begin wr_cnt++; last_wa = wr_addr_o; last_wd = wr_data_o; end
    if (meas_strobe_o) meas_cnt++;
    if (rd_req_o) rd_cnt++;
    if (rst_ni && scl_m && sda_oe_o != oe_prev) oe_viol++;
    oe_prev = sda_oe_o;
    if (cyc == 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 190000);
      summary();
      $finish;
    end
  end

  task automatic hw(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic pulse(output logic b);
    hw(H); scl_m = 1'b1; hw(H/2); b = sda_line; hw(H/2); scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b0; hw(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H); scl_m = 1'b1; hw(H); sda_m = 1'b1; hw(2*H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin sda_m = b[i]; pulse(x); end
    sda_m = 1'b1; pulse(x); ack = ~x;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic x;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin pulse(x); b[i] = x; end
    sda_m = ~mack; pulse(x); sda_m = 1'b1;
  endtask

  // pec_mode: 0 none, 1 correct, 2 corrupted
  task automatic do_write(input logic [7:0] ptr, input logic [7:0] dat, input int pec_mode,
                          input string req);
    logic a0, a1, a2, a3;
    logic [7:0] pec;
    int w0, m0;
    bit take, exp_wr;
    w0 = wr_cnt; m0 = meas_cnt; a3 = 1'b0;
    pec = crc_ref(crc_ref(crc_ref(8'h00, 8'h98), ptr), dat);
    if (pec_mode == 2) pec ^= 8'h10;
    bus_start();
    send_byte(8'h98, a0); send_byte(ptr, a1); send_byte(dat, a2);
    if (pec_mode != 0) send_byte(pec, a3);
    bus_stop(); hw(4);
    chk(req, "address ack", int'(a0), 1);
    chk(req, "pointer ack", int'(a1), 1);
    chk(req, "data ack", int'(a2), 1);
    if (pec_mode != 0) chk(req, "pec ack", int'(a3), int'(pec_mode == 1));
    take   = (pec_mode != 2);
    exp_wr = take && ptr < 8'd8;
    chk(req, "write strobes", wr_cnt - w0, int'(exp_wr));
    if (exp_wr) begin
      chk(req, "write address", int'(last_wa), int'(ptr));
      chk(req, "write data", int'(last_wd), int'(dat));
      model[ptr[2:0]] = dat;
    end
    chk(req, "command strobes", meas_cnt - m0, int'(take && ptr == 8'h0F));
  endtask

  task automatic do_read(input logic [7:0] ptr, input bit use_pec, input string req);
    logic a0, a1, a2;
    logic [7:0] d, p, exp_d;
    int r0;
    r0 = rd_cnt;
    exp_d = (ptr < 8'd8) ? model[ptr[2:0]] : (ptr ^ 8'h5A);
    bus_start();
    send_byte(8'h98, a0); send_byte(ptr, a1);
    bus_start();
    send_byte(8'h99, a2);
    recv_byte(use_pec, d);
    if (use_pec) recv_byte(1'b0, p);
    bus_stop(); hw(4);
    chk(req, "read acks", int'({a0, a1, a2}), 7);
    chk(req, "read data", int'(d), int'(exp_d));
    chk(req, "core requests", rd_cnt - r0, int'(ptr >= 8'd8));
    if (use_pec) chk("R9", "read pec", int'(p), int'(crc_ref(crc_ref(8'h00, 8'h99), d)));
  endtask

  initial begin
    logic a, b;
    logic [7:0] d, x;
    int w0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 8; i++) model[i] = '0;
    hw(5); rst_ni = 1'b1; hw(5);

    // reset state: line released, no strobes (R1)
    chk("R1", "reset oe", int'(sda_oe_o), 0);
    chk("R1", "reset strobes", int'({wr_valid_o, meas_strobe_o, rd_req_o}), 0);

    // foreign address 0x4B is ignored (R2)
    w0 = wr_cnt;
    bus_start(); send_byte(8'h96, a); send_byte(8'h03, b); bus_stop(); hw(4);
    chk("R2", "foreign address ack", int'(a), 0);
    chk("R2", "byte after foreign address ack", int'(b), 0);
    chk("R2", "foreign address writes", wr_cnt - w0, 0);

    // storage write and readback (R4, R5)
    do_write(8'h03, 8'hC5, 0, "R4");
    do_read(8'h03, 1'b0, "R5");
    do_read(8'h00, 1'b0, "R5");

    // command pointer (R7) and read-only pointer (R6)
    do_write(8'h0F, 8'h77, 0, "R7");
    do_write(8'h12, 8'h33, 0, "R6");
    do_read(8'h12, 1'b0, "R6");
    do_read(8'h0F, 1'b0, "R6");

    // packet checking on writes (R8), corrupted check byte with stop right behind
    do_write(8'h05, 8'h3C, 1, "R8");
    do_write(8'h05, 8'h99, 2, "R8");
    do_read(8'h05, 1'b1, "R8");
    do_write(8'h0F, 8'h01, 2, "R8");
    do_write(8'h0F, 8'hE2, 1, "R7");

    // repeated start drops a pending write (R1)
    w0 = wr_cnt;
    bus_start(); send_byte(8'h98, a); send_byte(8'h02, a); send_byte(8'h66, a);
    bus_start(); bus_stop(); hw(4);
    chk("R1", "write dropped by repeated start", wr_cnt - w0, 0);
    do_read(8'h02, 1'b0, "R1");

    // master NACK ends the read: next byte reads all ones (R10)
    bus_start(); send_byte(8'h98, a); send_byte(8'h03, a);
    bus_start(); send_byte(8'h99, a);
    recv_byte(1'b0, d);
    recv_byte(1'b0, x);
    bus_stop(); hw(4);
    chk("R10", "data before nack", int'(d), int'(model[3]));
    chk("R10", "line after nack", int'(x), 8'hFF);

    // read PEC on a read-only pointer (R9)
    do_read(8'h09, 1'b1, "R9");

    // random mix of pointers, data and check modes
    for (int n = 0; n < 24; n++) begin
      logic [7:0] rp, rd;
      int pm;
      rp = 8'($urandom_range(19, 0));
      rd = 8'($urandom);
      pm = int'($urandom_range(2, 0));
      do_write(rp, rd, pm, (pm == 0) ? "R4" : "R8");
    end
    for (int i = 0; i < 8; i++) do_read(8'(i), bit'($urandom_range(1, 0)), "R5");

    chk("R3", "drive changes with clock high", oe_viol, 0);
    summary();
    $finish;
  end
endmodule